// File: doc/BRIEF.md
# Virtual Interrupt Distributor Control Registers

This block keeps the top-level registers of a virtual interrupt distributor. It holds a global enable bit, a read-only type word that gives the size of the interrupt space and the number of CPUs, and an identification word. The identification word carries a revision field.

Two requesters reach the block through identical 32-bit register ports. The guest port serves ordinary software. The host port is privileged and may also update the identification revision. A host revision update is accepted only under strict checks. The first accepted update sets a sticky flag that allows the host to write the interrupt group registers, which live in a neighbouring block.

The block emits a one-cycle kick pulse toward all CPUs when the distributor is switched on.

Top module: `irqdist_ctrl_regs`

## Requirements
- R1: The register is selected by address bits [3:2]: 0 is control, 1 is type and 2 is identification. Select value 3 reads as zero and ignores writes. Every request is acknowledged on its port exactly one cycle after its valid. A write acknowledge returns read data zero.
- R2: Control bit 0 is the enable. It reads back as last written, and all other control bits read as zero.
- R3: A control write that changes the enable from 0 to 1 produces a `kick` pulse lasting exactly one cycle, in the same cycle as the write acknowledge. No other write pulses `kick`.
- R4: The type word holds ((NUM_SHARED + 32) / 32) - 1 in bits [4:0] and NUM_CPUS - 1 in bits [7:5]. All other bits are zero. With the defaults it reads 0x63.
- R5: The identification word has the product code in [31:24], zero in [23:16], the revision in [15:12] and the implementer code in [11:0]. With the defaults and revision 2 it reads 0x5A0021C3. Guest writes to the identification and type registers change nothing.
- R6: A host identification write in which any bit outside [15:12] differs from the current word is rejected. Rejection returns `h_err` = 1 with the acknowledge, and the state does not change.
- R7: A host identification write whose other bits match is accepted only when the new revision is 2 or 3. Acceptance stores the revision and sets the sticky `grp_unlock`. Any other revision is rejected as in R6.
- R8: Host writes to the control and type registers act exactly as guest writes and never raise `h_err`. When both ports write control in the same cycle, the host value wins.
- R9: After reset the enable is 0, `grp_unlock` is 0 and the revision equals REV_RESET (default 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| g_valid | input | 1 | Guest request valid |
| g_write | input | 1 | Guest request is a write |
| g_addr | input | ADDR_W | Guest byte address |
| g_wdata | input | 32 | Guest write data |
| g_ack | output | 1 | Guest acknowledge |
| g_rdata | output | 32 | Guest read data |
| h_valid | input | 1 | Host request valid |
| h_write | input | 1 | Host request is a write |
| h_addr | input | ADDR_W | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_ack | output | 1 | Host acknowledge |
| h_rdata | output | 32 | Host read data |
| h_err | output | 1 | Host write rejected (identification checks) |
| kick | output | 1 | One-cycle pulse on enable rising |
| grp_unlock | output | 1 | Sticky flag allowing host group-register writes |

## Verification
The embedded assertions check these rules on every cycle:
- `kick` only fires on a real 0-to-1 enable change.
- `grp_unlock` never falls once set.
- The revision moves only on an accepted host identification write.
- Acknowledges follow requests by one cycle, and errors come only with a host acknowledge.

The bench's scenarios show the rest:
- the exact read values of each register;
- that non-revision mismatches and illegal revisions are both refused without side effects;
- that guest writes to read-only registers are harmless;
- that the host wins a same-cycle control write collision.

// File: rtl/irqdist_pkg.sv
package irqdist_pkg;

  localparam int REG_W   = 32;
  localparam int REV_LSB = 12;
  localparam int REV_W   = 4;
  localparam logic [REG_W-1:0] REV_MASK = 32'h0000_F000;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_TYPE = 2'd1,
    SEL_ID   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Type word: [4:0] = lines/32 - 1, [7:5] = cpus - 1
  function automatic logic [REG_W-1:0] make_type_word(input int shared_lines, input int cpus);
    logic [REG_W-1:0] w;
    int lines;
    lines = shared_lines + 32;
    w = '0;
    w[4:0] = 5'((lines / 32) - 1);
    w[7:5] = 3'(cpus - 1);
    return w;
  endfunction

  function automatic logic [REG_W-1:0] make_id_word(input logic [7:0] prod,
                                                    input logic [REV_W-1:0] rev,
                                                    input logic [11:0] impl);
    return {prod, 8'h00, rev, impl};
  endfunction

  function automatic logic rev_is_legal(input logic [REV_W-1:0] rev);
    return (rev == 4'd2) || (rev == 4'd3);
  endfunction

endpackage

// File: rtl/irqdist_decode.sv
module irqdist_decode
  import irqdist_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    sel = reg_sel_e'(addr[3:2]);
  end
endmodule

// File: rtl/irqdist_read_mux.sv
module irqdist_read_mux
  import irqdist_pkg::*;
(
  input  reg_sel_e         sel,
  input  logic             en,
  input  logic [REG_W-1:0] type_word,
  input  logic [REG_W-1:0] id_word,
  output logic [REG_W-1:0] rdata
);
  always_comb begin
    unique case (sel)
      SEL_CTRL: rdata = {{(REG_W-1){1'b0}}, en};
      SEL_TYPE: rdata = type_word;
      SEL_ID:   rdata = id_word;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqdist_id_check.sv
module irqdist_id_check
  import irqdist_pkg::*;
(
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] cur_id,
  output logic             fixed_mismatch,
  output logic             rev_bad,
  output logic             accept,
  output logic [REV_W-1:0] new_rev
);
  always_comb begin
    new_rev        = wdata[REV_LSB +: REV_W];
    fixed_mismatch = |((wdata ^ cur_id) & ~REV_MASK);
    rev_bad        = !rev_is_legal(new_rev);
    accept         = !fixed_mismatch && !rev_bad;
  end
endmodule

// File: rtl/irqdist_ctrl_regs.sv
module irqdist_ctrl_regs
  import irqdist_pkg::*;
#(
  parameter int          ADDR_W     = 4,
  parameter int          NUM_SHARED = 96,
  parameter int          NUM_CPUS   = 4,
  parameter logic [7:0]  PRODUCT_ID = 8'h5A,
  parameter logic [11:0] IMPL_ID    = 12'h1C3,
  parameter logic [3:0]  REV_RESET  = 4'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              g_valid,
  input  logic              g_write,
  input  logic [ADDR_W-1:0] g_addr,
  input  logic [31:0]       g_wdata,
  output logic              g_ack,
  output logic [31:0]       g_rdata,
  input  logic              h_valid,
  input  logic              h_write,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [31:0]       h_wdata,
  output logic              h_ack,
  output logic [31:0]       h_rdata,
  output logic              h_err,
  output logic              kick,
  output logic              grp_unlock
);
  localparam int NPORT = 2;   // index 0 = guest, 1 = host
  localparam logic [REG_W-1:0] TYPE_WORD = make_type_word(NUM_SHARED, NUM_CPUS);

  logic             en_q, en_d;
  logic [REV_W-1:0] rev_q;
  logic [REG_W-1:0] id_word;

  logic [NPORT-1:0]             p_valid, p_write;
  logic [NPORT-1:0][ADDR_W-1:0] p_addr;
  logic [NPORT-1:0][REG_W-1:0]  p_wdata, p_mux, p_rdata_q;
  logic [NPORT-1:0]             p_ack_q;
  reg_sel_e                     p_sel [NPORT];
  logic [NPORT-1:0]             p_ctrl_wr;

  // Named internal events for the assertions
  logic             id_try, id_ok, id_fix_bad, id_rev_bad, rise_evt;
  logic [REV_W-1:0] id_new_rev;

  assign p_valid = {h_valid, g_valid};
  assign p_write = {h_write, g_write};
  assign p_addr  = {h_addr, g_addr};
  assign p_wdata = {h_wdata, g_wdata};

  assign id_word = make_id_word(PRODUCT_ID, rev_q, IMPL_ID);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    irqdist_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (p_addr[p]),
      .sel  (p_sel[p])
    );
    irqdist_read_mux u_mux (
      .sel       (p_sel[p]),
      .en        (en_q),
      .type_word (TYPE_WORD),
      .id_word   (id_word),
      .rdata     (p_mux[p])
    );
    assign p_ctrl_wr[p] = p_valid[p] && p_write[p] && (p_sel[p] == SEL_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        p_ack_q[p]   <= 1'b0;
        p_rdata_q[p] <= '0;
      end else begin
        p_ack_q[p]   <= p_valid[p];
        p_rdata_q[p] <= (p_valid[p] && !p_write[p]) ? p_mux[p] : '0;
      end
    end
  end

  irqdist_id_check u_idchk (
    .wdata          (h_wdata),
    .cur_id         (id_word),
    .fixed_mismatch (id_fix_bad),
    .rev_bad        (id_rev_bad),
    .accept         (id_ok),
    .new_rev        (id_new_rev)
  );

  assign id_try = h_valid && h_write && (p_sel[1] == SEL_ID);

  // Host wins a same-cycle control write collision
  always_comb begin
    en_d = en_q;
    if (p_ctrl_wr[0]) en_d = g_wdata[0];
    if (p_ctrl_wr[1]) en_d = h_wdata[0];
  end
  assign rise_evt = !en_q && en_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      kick       <= 1'b0;
      rev_q      <= REV_RESET;
      grp_unlock <= 1'b0;
      h_err      <= 1'b0;
    end else begin
      en_q  <= en_d;
      kick  <= rise_evt;
      h_err <= id_try && !id_ok;
      if (id_try && id_ok) begin
        rev_q      <= id_new_rev;
        grp_unlock <= 1'b1;
      end
    end
  end

  assign g_ack   = p_ack_q[0];
  assign h_ack   = p_ack_q[1];
  assign g_rdata = p_rdata_q[0];
  assign h_rdata = p_rdata_q[1];

  // R3: kick only accompanies a real 0->1 change of the stored enable
  a_r3_kick_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> (en_q && !$past(en_q)));
  // R3: kick never lasts two cycles
  a_r3_kick_single: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !kick);
  // R7: unlock flag is sticky
  a_r7_unlock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    grp_unlock |=> grp_unlock);
  // R7: revision moves only on an accepted host identification write
  a_r7_rev_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    (rev_q != $past(rev_q)) |-> $past(id_try && id_ok));
  // R6: an error only comes with a host acknowledge
  a_r6_err_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    h_err |-> h_ack);
  // R1: acknowledge one cycle after each request
  a_r1_guest_ack: assert property (@(posedge clk) disable iff (!rst_n)
    g_valid |=> g_ack);
  a_r1_host_ack: assert property (@(posedge clk) disable iff (!rst_n)
    h_valid |=> h_ack);
endmodule

// File: tb/irqdist_ctrl_regs_tb.sv
module irqdist_ctrl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        g_valid = 0, g_write = 0, h_valid = 0, h_write = 0;
  logic [3:0]  g_addr = 0, h_addr = 0;
  logic [31:0] g_wdata = 0, h_wdata = 0;
  logic        g_ack, h_ack, h_err, kick, grp_unlock;
  logic [31:0] g_rdata, h_rdata;

  int n_checks = 0;
  int n_fails  = 0;

  typedef struct {
    logic [31:0] rd;
    logic        err;
    logic        kck;
    logic        unl;
    string       tag;
  } exp_t;

  exp_t gq[$];
  exp_t hq[$];

  // bench model of the register state
  logic       m_en = 0;
  logic [3:0] m_rev = 4'd2;
  logic       m_unl = 0;

  always #5 clk = ~clk;

  irqdist_ctrl_regs dut_i (
    .clk(clk), .rst_n(rst_n),
    .g_valid(g_valid), .g_write(g_write), .g_addr(g_addr), .g_wdata(g_wdata),
    .g_ack(g_ack), .g_rdata(g_rdata),
    .h_valid(h_valid), .h_write(h_write), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_ack(h_ack), .h_rdata(h_rdata), .h_err(h_err),
    .kick(kick), .grp_unlock(grp_unlock)
  );

  function automatic logic [31:0] id_of(input logic [3:0] r);
    return (32'h5A << 24) | (32'(r) << 12) | 32'h1C3;
  endfunction

  function automatic logic [31:0] model_read(input logic [3:0] a);
    case (a[3:2])
      2'd0: return {31'd0, m_en};
      2'd1: return 32'h63;
      2'd2: return id_of(m_rev);
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // host identification write outcome: returns error, updates model
  function automatic logic host_id_write(input logic [31:0] wd);
    logic [31:0] cur;
    cur = id_of(m_rev);
    if (((wd ^ cur) & 32'hFFFF0FFF) != 0) return 1'b1;
    if (wd[15:12] == 4'd2 || wd[15:12] == 4'd3) begin
      m_rev = wd[15:12];
      m_unl = 1'b1;
      return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic dual(input logic gv, input logic gw, input logic [3:0] ga, input logic [31:0] gd,
                      input logic hv, input logic hw, input logic [3:0] ha, input logic [31:0] hd,
                      input string tag);
    exp_t ge, he;
    logic old_en, new_en, err;
    @(negedge clk);
    old_en = m_en;
    ge.rd = (gv && !gw) ? model_read(ga) : 32'd0;
    he.rd = (hv && !hw) ? model_read(ha) : 32'd0;
    new_en = m_en;
    err = 1'b0;
    if (gv && gw && ga[3:2] == 2'd0) new_en = gd[0];
    if (hv && hw && ha[3:2] == 2'd0) new_en = hd[0];
    if (hv && hw && ha[3:2] == 2'd2) err = host_id_write(hd);
    m_en = new_en;
    ge.err = 0; he.err = err;
    ge.kck = !old_en && new_en; he.kck = ge.kck;
    ge.unl = m_unl; he.unl = m_unl;
    ge.tag = tag; he.tag = tag;
    if (gv) gq.push_back(ge);
    if (hv) hq.push_back(he);
    g_valid = gv; g_write = gw; g_addr = ga; g_wdata = gd;
    h_valid = hv; h_write = hw; h_addr = ha; h_wdata = hd;
    @(negedge clk);
    g_valid = 0; h_valid = 0;
  endtask

  task automatic gacc(input logic w, input logic [3:0] a, input logic [31:0] d, input string tag);
    dual(1'b1, w, a, d, 1'b0, 1'b0, 4'd0, 32'd0, tag);
  endtask

  task automatic hacc(input logic w, input logic [3:0] a, input logic [31:0] d, input string tag);
    dual(1'b0, 1'b0, 4'd0, 32'd0, 1'b1, w, a, d, tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (g_ack) begin
        if (gq.size() == 0) chk(1'b0, "R1 unexpected guest ack", 32'd1, 32'd0);
        else begin
          exp_t e;
          e = gq.pop_front();
          chk(g_rdata === e.rd, {e.tag, " guest rdata"}, g_rdata, e.rd);
          chk(kick === e.kck, {e.tag, " R3 kick"}, 32'(kick), 32'(e.kck));
          chk(grp_unlock === e.unl, {e.tag, " R7 unlock"}, 32'(grp_unlock), 32'(e.unl));
        end
      end
      if (h_ack) begin
        if (hq.size() == 0) chk(1'b0, "R1 unexpected host ack", 32'd1, 32'd0);
        else begin
          exp_t e;
          e = hq.pop_front();
          chk(h_rdata === e.rd, {e.tag, " host rdata"}, h_rdata, e.rd);
          chk(h_err === e.err, {e.tag, " R6 h_err"}, 32'(h_err), 32'(e.err));
          chk(kick === e.kck, {e.tag, " R3 kick"}, 32'(kick), 32'(e.kck));
          chk(grp_unlock === e.unl, {e.tag, " R7 unlock"}, 32'(grp_unlock), 32'(e.unl));
        end
      end
      if (!g_ack && !h_ack && kick === 1'b1)
        chk(1'b0, "R3 kick without write", 32'd1, 32'd0);
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(kick === 1'b0, "R9 kick after reset", 32'(kick), 32'd0);
    chk(grp_unlock === 1'b0, "R9 unlock after reset", 32'(grp_unlock), 32'd0);
    chk(g_ack === 1'b0 && h_err === 1'b0, "R9 idle outputs", 32'(h_err), 32'd0);
    gacc(0, 4'h0, 0, "R9 enable reset 0");
    gacc(0, 4'h8, 0, "R9 R5 id reset rev 2");
    // R4, R1
    gacc(0, 4'h4, 0, "R4 type word");
    gacc(0, 4'hC, 0, "R1 unused offset reads zero");
    gacc(1, 4'hC, 32'hFFFF_FFFF, "R1 unused offset write ignored");
    // R2, R3
    gacc(1, 4'h0, 32'hFFFF_FFFF, "R3 enable rise kicks");
    gacc(0, 4'h0, 0, "R2 enable reads 1, other bits 0");
    gacc(1, 4'h0, 32'h1, "R3 rewrite 1 no kick");
    gacc(1, 4'h0, 32'h0, "R2 disable");
    gacc(0, 4'h0, 0, "R2 enable reads 0");
    // R5: guest writes to read-only registers
    gacc(1, 4'h4, 32'h0, "R5 guest type write");
    gacc(0, 4'h4, 0, "R5 type unchanged");
    gacc(1, 4'h8, id_of(4'd3), "R5 guest id write");
    gacc(0, 4'h8, 0, "R5 id unchanged");
    // R6: mismatch outside revision
    hacc(1, 4'h8, id_of(4'd3) ^ 32'h0100_0000, "R6 product mismatch");
    hacc(1, 4'h8, id_of(4'd3) ^ 32'h0000_0001, "R6 implementer mismatch");
    hacc(0, 4'h8, 0, "R6 id unchanged after reject");
    // R7: illegal revisions
    hacc(1, 4'h8, id_of(4'd5), "R7 rev 5 rejected");
    hacc(1, 4'h8, id_of(4'd1), "R7 rev 1 rejected");
    hacc(1, 4'h8, id_of(4'd3), "R7 rev 3 accepted");
    hacc(0, 4'h8, 0, "R7 id shows rev 3");
    hacc(1, 4'h8, id_of(4'd2), "R7 rev 2 accepted, unlock stays");
    hacc(1, 4'h8, id_of(4'd4), "R7 rev 4 rejected, unlock stays");
    // R8
    hacc(1, 4'h0, 32'h1, "R8 host enable kicks");
    hacc(0, 4'h0, 0, "R8 host reads enable");
    hacc(1, 4'h4, 32'hFFFF_FFFF, "R8 host type write no error");
    hacc(0, 4'h4, 0, "R8 type unchanged");
    hacc(1, 4'h0, 32'h0, "R8 host disable");
    dual(1, 1, 4'h0, 32'h0, 1, 1, 4'h0, 32'h1, "R8 collision host wins");
    gacc(0, 4'h0, 0, "R8 enable after collision");
    dual(1, 1, 4'h0, 32'h0, 1, 1, 4'h0, 32'h0, "R8 both clear");
    dual(1, 0, 4'h8, 0, 1, 0, 4'h4, 0, "R1 dual reads");
    repeat (3) @(negedge clk);
    chk(gq.size() == 0 && hq.size() == 0, "R1 all requests acknowledged",
        32'(gq.size() + hq.size()), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule